// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block takes the level-sensitive interrupt pins of a group of PCI devices and steers them onto sixteen level outputs that feed a legacy interrupt controller pair. Each device's four pins first pass through a fixed swizzle that depends on the device's slot number. The swizzle folds all pins onto four shared interrupt request channels, called channels A to D below. Each channel then goes through a programmable route register that names the output line it drives, or that turns the channel off.

Routing is set through a byte-wide configuration port with separate read and write data buses. The block keeps a 16×4 level map. A bit in that map means "this channel is high and is routed to this line". Each output is the OR of that line's four map bits. A change in a channel's level updates only that channel's bit. A write to any route register clears the map and rebuilds it from the present channel levels. A query port reports the route of any channel: whether it is enabled, and which line it uses.

Top module: `pirq_router`

## Requirements
- R1: After reset every route register reads 0x80, the query port reports every channel disabled with line 0, and all sixteen outputs are low.
- R2: A write strobe with offset 0x60+k (k = 0..3, channel A..D) stores the write data into channel k's route register. A read at offset 0x60+k returns that stored byte. A read at any other offset returns 0x00.
- R3: Writes to offsets outside 0x60..0x63 change no route register and no output.
- R4: A route value of 16 or more (any of bits 7..4 set) disables its channel. A disabled channel drives no output, and the query reports it with enable 0 and line 0.
- R5: For a route value below 16, the query reports enable 1, and bits 3..0 of the value give the line number.
- R6: The pin at devPins[d*4+i] belongs to device number FIRST_DEV+d, pin i (INTA=0 .. INTD=3). It feeds channel (i + FIRST_DEV + d − 1) mod 4.
- R7: A channel's level is the OR of every pin that swizzles onto it. Each output line is the OR of every enabled channel routed to that line.
- R8: A change on a device pin shows on the outputs exactly one clock edge later, and not before.
- R9: A route write takes effect on the outputs one clock edge after the write strobe. A channel never drives more than one line, so moving a channel releases its old line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgAddr | input | 8 | Configuration byte offset for reads and writes |
| cfgWrData | input | 8 | Configuration write data |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgRdData | output | 8 | Configuration read data, combinational from cfgAddr |
| devPins | input | NUM_DEV*4 | Device interrupt pins, four per device, INTA in the lowest bit |
| qryPirq | input | 2 | Channel selected for a route query |
| qryEnable | output | 1 | The selected channel is enabled |
| qryLine | output | 4 | Output line of the selected channel, 0 when disabled |
| lineOut | output | 16 | Level outputs toward the interrupt controller |

## Verification
The in-RTL assertions check three things on every cycle. Each channel occupies at most one bit of the level map. No output is high unless some channel was high on the previous cycle. An all-disabled route table leaves the outputs low. The same assertions also confirm that out-of-window writes leave the registers stable and that in-window writes land. The swizzle arithmetic, the exact one-edge latency, the rebuild that moves a channel between lines, and the OR of several pins and channels onto one line can only be shown by the bench's scenarios. The bench runs these against its behavioural model, which is compared with the outputs on every clock.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;
  localparam int PIRQ_COUNT  = 4;
  localparam int LINE_COUNT  = 16;
  localparam int ROUTE_W     = 8;
  localparam int ROUTE_BASE  = 'h60;
  localparam int ROUTE_RESET = 'h80;

  // strobes from control to datapath
  typedef struct packed {
    logic rebuild;   // a route register is being written this cycle
  } routeStrb_t;
endpackage

// File: rtl/pirq_route_ctrl.sv
module pirq_route_ctrl
  import pirq_route_pkg::*;
#(
  parameter int NUM_PIRQ  = PIRQ_COUNT,
  parameter int NUM_LINES = LINE_COUNT,
  parameter int RW        = ROUTE_W,
  parameter int BASE      = ROUTE_BASE
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [7:0]                   cfgAddr,
  input  logic [RW-1:0]                cfgWrData,
  input  logic                         cfgWrEn,
  output logic [RW-1:0]                cfgRdData,
  input  logic [$clog2(NUM_PIRQ)-1:0]  qryPirq,
  output logic                         qryEnable,
  output logic [$clog2(NUM_LINES)-1:0] qryLine,
  output logic [NUM_PIRQ-1:0][RW-1:0]  routeEff,
  output routeStrb_t                   strb
);
  localparam int PW = $clog2(NUM_PIRQ);
  localparam int LW = $clog2(NUM_LINES);
  localparam logic [7:0]    FIRST8 = 8'(BASE);
  localparam logic [7:0]    LAST8  = 8'(BASE + NUM_PIRQ - 1);
  localparam logic [RW-1:0] LIM    = RW'(NUM_LINES);
  localparam logic [RW-1:0] RST_V  = RW'(ROUTE_RESET);

  logic [NUM_PIRQ-1:0][RW-1:0] routeReg;
  logic          inWin;
  logic [PW-1:0] winIdx;
  logic [RW-1:0] qSel;

  assign inWin  = (cfgAddr >= FIRST8) && (cfgAddr <= LAST8);
  assign winIdx = PW'(cfgAddr - FIRST8);

  always_comb begin
    routeEff = routeReg;
    if (cfgWrEn && inWin) routeEff[winIdx] = cfgWrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PIRQ; p++) routeReg[p] <= RST_V;
    end else begin
      routeReg <= routeEff;
    end
  end

  assign strb.rebuild = cfgWrEn && inWin;
  assign cfgRdData    = inWin ? routeReg[winIdx] : '0;

  assign qSel      = routeReg[qryPirq];
  assign qryEnable = qSel < LIM;
  assign qryLine   = qryEnable ? qSel[LW-1:0] : '0;

  AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfgWrEn && !inWin) |=> $stable(routeReg)); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (cfgWrEn && inWin) |=> (routeReg[$past(winIdx)] == $past(cfgWrData))); // R2
endmodule

// File: rtl/pirq_level_dp.sv
module pirq_level_dp
  import pirq_route_pkg::*;
#(
  parameter int NUM_PIRQ  = PIRQ_COUNT,
  parameter int NUM_LINES = LINE_COUNT,
  parameter int RW        = ROUTE_W,
  parameter int NUM_DEV   = 4,
  parameter int FIRST_DEV = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_DEV*NUM_PIRQ-1:0]   devPins,
  input  logic [NUM_PIRQ-1:0][RW-1:0]   routeEff,
  input  routeStrb_t                    strb,
  output logic [NUM_LINES-1:0]          lineOut
);
  localparam int LW     = $clog2(NUM_LINES);
  localparam int MAP_W  = NUM_LINES * NUM_PIRQ;
  localparam logic [RW-1:0] LIM = RW'(NUM_LINES);

  logic [NUM_PIRQ-1:0] pirqLevel;
  logic [NUM_PIRQ-1:0] levelPrev;
  logic [NUM_PIRQ-1:0] routeOk;
  logic [MAP_W-1:0]    levelMap;
  logic [MAP_W-1:0]    mapNext;

  // slot swizzle: pin i of device number n lands on channel (i + n - 1) mod NUM_PIRQ
  always_comb begin
    pirqLevel = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      for (int i = 0; i < NUM_PIRQ; i++) begin
        if (devPins[d*NUM_PIRQ + i]) pirqLevel[(i + FIRST_DEV + d - 1) % NUM_PIRQ] = 1'b1;
      end
    end
  end

  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_ok
    assign routeOk[p] = routeEff[p] < LIM;
  end

  always_comb begin
    mapNext = levelMap;
    if (strb.rebuild) mapNext = '0;
    for (int p = 0; p < NUM_PIRQ; p++) begin
      automatic int pos = int'(routeEff[p][LW-1:0]) * NUM_PIRQ + p;
      if (routeOk[p] && (strb.rebuild || (pirqLevel[p] != levelPrev[p])))
        mapNext[pos] = pirqLevel[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      levelMap  <= '0;
      levelPrev <= '0;
    end else begin
      levelMap  <= mapNext;
      levelPrev <= pirqLevel;
    end
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign lineOut[l] = |levelMap[l*NUM_PIRQ +: NUM_PIRQ];
  end

  // per-channel column of the map, for the single-line check
  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_col
    logic [NUM_LINES-1:0] col;
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_bit
      assign col[l] = levelMap[l*NUM_PIRQ + p];
    end
    AST_ONE_LINE_PER_PIRQ: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col)); // R9
  end

  AST_LINE_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (|lineOut) |-> $past(|pirqLevel)); // R7

  AST_ALL_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (routeOk == '0) |=> (lineOut == '0)); // R4
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_route_pkg::*;
#(
  parameter int NUM_PIRQ  = PIRQ_COUNT,
  parameter int NUM_LINES = LINE_COUNT,
  parameter int NUM_DEV   = 4,
  parameter int FIRST_DEV = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [7:0]                    cfgAddr,
  input  logic [7:0]                    cfgWrData,
  input  logic                          cfgWrEn,
  output logic [7:0]                    cfgRdData,
  input  logic [NUM_DEV*NUM_PIRQ-1:0]   devPins,
  input  logic [$clog2(NUM_PIRQ)-1:0]   qryPirq,
  output logic                          qryEnable,
  output logic [$clog2(NUM_LINES)-1:0]  qryLine,
  output logic [NUM_LINES-1:0]          lineOut
);
  logic [NUM_PIRQ-1:0][7:0] routeEff;
  routeStrb_t               strb;

  pirq_route_ctrl #(
    .NUM_PIRQ(NUM_PIRQ), .NUM_LINES(NUM_LINES), .RW(8), .BASE(ROUTE_BASE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .cfgWrEn(cfgWrEn), .cfgRdData(cfgRdData), .qryPirq(qryPirq),
    .qryEnable(qryEnable), .qryLine(qryLine), .routeEff(routeEff), .strb(strb)
  );

  pirq_level_dp #(
    .NUM_PIRQ(NUM_PIRQ), .NUM_LINES(NUM_LINES), .RW(8),
    .NUM_DEV(NUM_DEV), .FIRST_DEV(FIRST_DEV)
  ) u_dp (
    .clk(clk), .rst(rst), .devPins(devPins), .routeEff(routeEff),
    .strb(strb), .lineOut(lineOut)
  );
endmodule

// File: tb/pirq_router_bench.sv
module pirq_router_bench;
  localparam int NDEV  = 4;
  localparam int FIRST = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfgAddr = '0;
  logic [7:0]  cfgWrData = '0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgRdData;
  logic [NDEV*4-1:0] devPins = '0;
  logic [1:0]  qryPirq = '0;
  logic        qryEnable;
  logic [3:0]  qryLine;
  logic [15:0] lineOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pirq_router #(.NUM_DEV(NDEV), .FIRST_DEV(FIRST)) u_pirq_router (
    .clk(clk), .rst(rst), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .cfgWrEn(cfgWrEn), .cfgRdData(cfgRdData), .devPins(devPins),
    .qryPirq(qryPirq), .qryEnable(qryEnable), .qryLine(qryLine),
    .lineOut(lineOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model: route table and expected outputs
  int mRoute[4];
  logic [15:0] mExp;
  bit mValid = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < 4; p++) mRoute[p] = 'h80;
      mExp = '0;
      mValid = 0;
    end else begin
      bit lvl[4];
      if (cfgWrEn && cfgAddr >= 8'h60 && cfgAddr <= 8'h63) mRoute[cfgAddr - 8'h60] = cfgWrData;
      for (int p = 0; p < 4; p++) lvl[p] = 0;
      for (int d = 0; d < NDEV; d++)
        for (int i = 0; i < 4; i++)
          if (devPins[d*4+i]) lvl[(i + d + FIRST - 1) % 4] = 1;
      mExp = '0;
      for (int p = 0; p < 4; p++)
        if (lvl[p] && mRoute[p] < 16) mExp[mRoute[p]] = 1'b1;
      mValid = 1;
    end
  end

  always @(negedge clk) begin
    if (mValid && !rst && !done) check("R8 per-cycle model", int'(lineOut), int'(mExp));
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWrData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input int exp);
    @(negedge clk);
    cfgAddr = a;
    #1 check(req, int'(cfgRdData), exp);
  endtask

  task automatic qry(input string req, input int p, input int en, input int line);
    qryPirq = 2'(p);
    #1;
    check(req, int'(qryEnable), en);
    check(req, int'(qryLine), line);
  endtask

  task automatic pins(input logic [NDEV*4-1:0] v);
    @(negedge clk);
    devPins = v;
  endtask

  task automatic lines(input string req, input int exp);
    @(negedge clk);
    #1 check(req, int'(lineOut), exp);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int p = 0; p < 4; p++) rd("R1 reset route", 8'h60 + 8'(p), 'h80);
    for (int p = 0; p < 4; p++) qry("R1 reset query", p, 0, 0);
    check("R1 reset lines", int'(lineOut), 0);

    // R4: channel A high but disabled
    pins(16'h0001);
    lines("R4 disabled no drive", 0);
    lines("R4 disabled no drive", 0);

    // R9/R2/R5: route A to line 5
    @(negedge clk);
    cfgAddr = 8'h60; cfgWrData = 8'h05; cfgWrEn = 1'b1;
    #1 check("R9 not before edge", int'(lineOut), 0);
    @(negedge clk); cfgWrEn = 1'b0;
    #1 check("R9 one edge after write", int'(lineOut), 16'h0020);
    rd("R2 readback", 8'h60, 'h05);
    qry("R5 query enabled", 0, 1, 5);

    // R6: device 2 INTD -> channel A; R8 latency
    @(negedge clk);
    devPins = 16'h0080;
    #1 check("R8 old value before edge", int'(lineOut), 16'h0020);
    lines("R6 dev2 INTD on A", 16'h0020);
    @(negedge clk);
    devPins = 16'h0000;
    #1 check("R8 held before edge", int'(lineOut), 16'h0020);
    lines("R8 release one edge", 0);

    // R6/R7: device 4 INTA -> channel D; share line 5 with A
    wr(8'h63, 8'h05);
    pins(16'h1000);
    lines("R6 dev4 INTA on D", 16'h0020);
    pins(16'h1001);
    lines("R7 two channels one line", 16'h0020);
    pins(16'h0001);
    lines("R7 remaining channel holds", 16'h0020);
    pins(16'h1001);
    lines("R7 both again", 16'h0020);
    // two pins onto channel A: dev1 INTA and dev2 INTD
    pins(16'h1081);
    pins(16'h1080);
    lines("R7 pin OR on channel", 16'h0020);

    // R9 move A to line 9; D remains on 5
    wr(8'h60, 8'h09);
    check("R9 moved", int'(lineOut), 16'h0220);
    wr(8'h63, 8'h8F);
    check("R9 disable releases line", int'(lineOut), 16'h0200);
    qry("R4 query disabled", 3, 0, 0);

    // R3 outside-window writes
    wr(8'h64, 8'h03);
    wr(8'h5F, 8'h02);
    rd("R3 route A kept", 8'h60, 'h09);
    rd("R3 route D kept", 8'h63, 'h8F);
    rd("R2 outside read zero", 8'h64, 0);
    rd("R2 outside read zero", 8'h10, 0);
    check("R3 lines unchanged", int'(lineOut), 16'h0200);

    // R4/R5 boundary values
    wr(8'h60, 8'h10);
    qry("R4 value 16 disables", 0, 0, 0);
    check("R4 value 16 no drive", int'(lineOut), 0);
    wr(8'h60, 8'h0F);
    qry("R5 value 15 valid", 0, 1, 15);
    check("R5 line 15 driven", int'(lineOut), 16'h8000);

    // randomized phase against the model
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      devPins = 16'($urandom);
      if (($urandom % 4) == 0) begin
        cfgAddr = 8'h5E + 8'($urandom % 8);
        cfgWrData = ($urandom % 3 == 0) ? 8'($urandom) : 8'($urandom % 16);
        cfgWrEn = 1'b1;
      end else begin
        cfgWrEn = 1'b0;
      end
    end
    @(negedge clk); cfgWrEn = 1'b0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule